// File: doc/BRIEF.md
# Link Status Event Capture Register

This block is a 16-bit status register for one serial-link port. Its bandwidth-change event bits are set by hardware and cleared by software. It also shows software whether link training is in progress, whether the data-link layer is active, and the negotiated width and speed. Software accesses it through a simple register port: a write strobe, two byte enables, write data and a continuously driven read value. A separate strobe marks each write of 1 to the retrain-link control bit. That control bit lives in a neighbouring register.

The training state machine, the physical layer and the data-link control logic lie outside the block. They appear only as input signals. The block tracks one retrain request from the write, through the start of training, to completion, and it raises an event when that request finishes. Every field the register shows is a registered copy, so any input change appears at the read port one clock later.

Top module: `lnk_stat_reg`

## Requirements
- R1: Reset is synchronous and active-high. While reset is applied, and on the first read after it, the register reads 16'h1000.
- R2: Bit 15 (autonomous bandwidth event) is set when `hw_bw_auto` is high. It is also set when `phy_bw_chg` and `phy_bw_auto` are both high.
- R3: Bit 14 (bandwidth management event) is set when `hw_bw_fix` is high. It is also set when `phy_bw_chg` is high while `phy_bw_auto` is low.
- R4: Bit 14 is set on every `retrain_wr` pulse, including a pulse that arrives while `ltssm_cfg_rec` is already high.
- R5: Bit 14 is set when a retrain request completes. A request completes when training has started (`train_started` seen while the request is pending) and `ltssm_cfg_rec` then falls. A fall of `ltssm_cfg_rec` that no retrain write started sets nothing.
- R6: Bits 15 and 14 clear when a write has `cfg_be[1]` high and a 1 in that bit position. Writing 0, or writing with `cfg_be[1]` low, leaves them unchanged.
- R7: If a hardware set and a software clear hit the same event bit in the same cycle, the bit stays set.
- R8: Bandwidth events of any source are dropped while `dl_down` is high.
- R9: Bit 11 (training) reads 1 while `ltssm_cfg_rec` is high. It also reads 1 from a `retrain_wr` pulse until `train_started` is seen. Otherwise it reads 0.
- R10: Bit 13 follows `dl_active` when parameter `DLL_ACT_CAP` is 1, which is the default. When the parameter is 0, bit 13 is tied to 0.
- R11: Bit 12 always reads 1 and bit 10 always reads 0. Writes do not change any read-only bit.
- R12: Bits 9:4 show `neg_width` and bits 3:0 show `neg_speed`.
- R13: A read returns the value registered at the last clock edge. Any update appears on `cfg_rdata` after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_be | input | 2 | Byte enables, bit 1 covers data bits 15:8 |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current register value |
| retrain_wr | input | 1 | Pulse: 1 written to the retrain-link control bit |
| ltssm_cfg_rec | input | 1 | Training state machine is in Configuration or Recovery |
| train_started | input | 1 | Link training has begun |
| dl_active | input | 1 | Data-link control is in the active state |
| dl_down | input | 1 | Data-link layer is down |
| hw_bw_auto | input | 1 | Hardware changed speed or width on its own initiative |
| hw_bw_fix | input | 1 | Hardware changed speed or width to repair an unreliable link |
| phy_bw_chg | input | 1 | Physical layer reports a change started by the downstream side |
| phy_bw_auto | input | 1 | That reported change is tagged autonomous |
| neg_width | input | 6 | Negotiated link width |
| neg_speed | input | 4 | Negotiated link speed |

## Verification
A wrong event bit stays wrong at the port until software clears it. A missed or spurious set is therefore visible on `cfg_rdata` one edge after the cause and remains there, and each vector in the sequence checks the whole word at that point. A broken retrain tracker looks different: bit 11 stays high or drops early, or bit 14 fails to rise on the cycle after `ltssm_cfg_rec` falls. This is why the sequence walks a complete request across several cycles and also includes a fall of `ltssm_cfg_rec` that no retrain write started.

// File: rtl/lnk_stat_pkg.sv
package lnk_stat_pkg;

    localparam int WIDTH_W = 6;
    localparam int SPEED_W = 4;
    localparam int WORD_W  = 16;

    localparam logic [WORD_W-1:0] RST_VAL = 16'h1000;

    localparam int EV_AUTO = 1;
    localparam int EV_MGMT = 0;
    localparam int EV_N    = 2;

    typedef struct packed {
        logic               evt_auto;
        logic               evt_mgmt;
        logic               dl_act;
        logic               slot_clk;
        logic               training;
        logic               rsvd;
        logic [WIDTH_W-1:0] width;
        logic [SPEED_W-1:0] speed;
    } stat_word_t;

    function automatic logic [EV_N-1:0] w1c_hits(input logic wr,
                                                 input logic [1:0] be,
                                                 input logic [WORD_W-1:0] wd);
        logic [EV_N-1:0] h;
        h[EV_AUTO] = wr & be[1] & wd[15];
        h[EV_MGMT] = wr & be[1] & wd[14];
        return h;
    endfunction

    function automatic logic sticky_next(input logic q, input logic set,
                                         input logic clr);
        return set | (q & ~clr);
    endfunction

endpackage

// File: rtl/lnk_w1c_evt.sv
module lnk_w1c_evt (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    import lnk_stat_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= sticky_next(q, set, clr);
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (!set && clr) |=> !q);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/lnk_train_trk.sv
module lnk_train_trk (
    input  logic clk,
    input  logic rst,
    input  logic retrain_wr,
    input  logic cfg_rec,
    input  logic train_started,
    input  logic dl_down,
    output logic training,
    output logic done
);
    logic pend_q, act_q, cfg_q;
    logic pend_nx, act_nx;

    always_comb begin
        done    = act_q & cfg_q & ~cfg_rec;
        pend_nx = retrain_wr | (pend_q & ~train_started & ~dl_down);
        act_nx  = (act_q | (pend_q & train_started)) & ~done & ~dl_down;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            act_q    <= 1'b0;
            cfg_q    <= 1'b0;
            training <= 1'b0;
        end else begin
            pend_q   <= pend_nx;
            act_q    <= act_nx;
            cfg_q    <= cfg_rec;
            training <= cfg_rec | pend_nx;
        end
    end

    p_retrain_pending_r9: assert property (@(posedge clk) disable iff (rst)
        retrain_wr |=> training);
    p_cfg_shows_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_rec |=> training);
    p_done_once_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/lnk_evt_src.sv
module lnk_evt_src
    import lnk_stat_pkg::*;
(
    input  logic            dl_down,
    input  logic            hw_bw_auto,
    input  logic            hw_bw_fix,
    input  logic            phy_bw_chg,
    input  logic            phy_bw_auto,
    input  logic            retrain_wr,
    input  logic            retrain_done,
    output logic [EV_N-1:0] ev_set
);
    always_comb begin
        ev_set[EV_AUTO] = hw_bw_auto | (phy_bw_chg & phy_bw_auto);
        ev_set[EV_MGMT] = hw_bw_fix | (phy_bw_chg & ~phy_bw_auto)
                        | retrain_wr | retrain_done;
        if (dl_down) ev_set = '0;
    end

    always_comb begin
        if (dl_down) a_mask_r8: assert (ev_set == '0);
    end
endmodule

// File: rtl/lnk_stat_reg.sv
module lnk_stat_reg #(
    parameter bit DLL_ACT_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_be,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        retrain_wr,
    input  logic        ltssm_cfg_rec,
    input  logic        train_started,
    input  logic        dl_active,
    input  logic        dl_down,
    input  logic        hw_bw_auto,
    input  logic        hw_bw_fix,
    input  logic        phy_bw_chg,
    input  logic        phy_bw_auto,
    input  logic [5:0]  neg_width,
    input  logic [3:0]  neg_speed
);
    import lnk_stat_pkg::*;

    logic [EV_N-1:0]    ev_set, ev_clr, ev_q;
    logic               trk_training, trk_done;
    logic               dl_act_q;
    logic [WIDTH_W-1:0] width_q;
    logic [SPEED_W-1:0] speed_q;
    stat_word_t         word;

    assign ev_clr = w1c_hits(cfg_wr, cfg_be, cfg_wdata);

    lnk_train_trk u_trk (
        .clk           (clk),
        .rst           (rst),
        .retrain_wr    (retrain_wr),
        .cfg_rec       (ltssm_cfg_rec),
        .train_started (train_started),
        .dl_down       (dl_down),
        .training      (trk_training),
        .done          (trk_done)
    );

    lnk_evt_src u_src (
        .dl_down      (dl_down),
        .hw_bw_auto   (hw_bw_auto),
        .hw_bw_fix    (hw_bw_fix),
        .phy_bw_chg   (phy_bw_chg),
        .phy_bw_auto  (phy_bw_auto),
        .retrain_wr   (retrain_wr),
        .retrain_done (trk_done),
        .ev_set       (ev_set)
    );

    for (genvar i = 0; i < EV_N; i++) begin : g_evt
        lnk_w1c_evt u_bit (
            .clk (clk),
            .rst (rst),
            .set (ev_set[i]),
            .clr (ev_clr[i]),
            .q   (ev_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_act_q <= 1'b0;
            width_q  <= '0;
            speed_q  <= '0;
        end else begin
            dl_act_q <= dl_active & DLL_ACT_CAP;
            width_q  <= neg_width;
            speed_q  <= neg_speed;
        end
    end

    always_comb begin
        word          = '0;
        word.evt_auto = ev_q[EV_AUTO];
        word.evt_mgmt = ev_q[EV_MGMT];
        word.dl_act   = dl_act_q;
        word.slot_clk = RST_VAL[12];
        word.training = trk_training;
        word.rsvd     = 1'b0;
        word.width    = width_q;
        word.speed    = speed_q;
    end

    assign cfg_rdata = word;

    p_reset_val_r1: assert property (@(posedge clk)
        rst |=> cfg_rdata == RST_VAL);
    p_fixed_bits_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[12] && !cfg_rdata[10]);
    p_dll_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cfg_rdata[13] == ($past(dl_active) && DLL_ACT_CAP));
    p_down_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
        dl_down |=> !$rose(cfg_rdata[15]) && !$rose(cfg_rdata[14]));
    p_fields_r12: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cfg_rdata[9:0] == {$past(neg_width), $past(neg_speed)});
endmodule

// File: tb/tb_lnk_stat_reg.sv
module tb_lnk_stat_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        retrain_wr = 1'b0, ltssm_cfg_rec = 1'b0, train_started = 1'b0;
    logic        dl_active = 1'b0, dl_down = 1'b0;
    logic        hw_bw_auto = 1'b0, hw_bw_fix = 1'b0;
    logic        phy_bw_chg = 1'b0, phy_bw_auto = 1'b0;
    logic [5:0]  neg_width = 6'h0;
    logic [3:0]  neg_speed = 4'h0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lnk_stat_reg dut (.*);

    // {req, wr, be, wdata, events, expected}
    // events: retrain, cfg_rec, started, down, hw_auto, hw_fix, phy, phy_auto
    localparam int NV = 25;
    localparam logic [46:0] VEC [NV] = '{
        {4'd12, 1'b0, 2'b00, 16'h0000, 8'h00, 16'h3042}, // R12 idle
        {4'd2,  1'b0, 2'b00, 16'h0000, 8'h08, 16'hB042}, // R2 hw auto
        {4'd6,  1'b0, 2'b00, 16'h0000, 8'h00, 16'hB042}, // R6 sticky
        {4'd6,  1'b1, 2'b10, 16'h0000, 8'h00, 16'hB042}, // R6 write 0
        {4'd6,  1'b1, 2'b01, 16'h8000, 8'h00, 16'hB042}, // R6 lane off
        {4'd6,  1'b1, 2'b10, 16'h8000, 8'h00, 16'h3042}, // R6 clear
        {4'd2,  1'b0, 2'b00, 16'h0000, 8'h03, 16'hB042}, // R2 phy auto
        {4'd11, 1'b1, 2'b11, 16'hFFFF, 8'h00, 16'h3042}, // R11 RO ignored
        {4'd3,  1'b0, 2'b00, 16'h0000, 8'h02, 16'h7042}, // R3 phy non-auto
        {4'd7,  1'b1, 2'b10, 16'h4000, 8'h04, 16'h7042}, // R7 set wins
        {4'd6,  1'b1, 2'b10, 16'h4000, 8'h00, 16'h3042}, // R6
        {4'd8,  1'b0, 2'b00, 16'h0000, 8'h18, 16'h3042}, // R8
        {4'd8,  1'b0, 2'b00, 16'h0000, 8'h12, 16'h3042}, // R8
        {4'd4,  1'b0, 2'b00, 16'h0000, 8'h80, 16'h7842}, // R4 retrain
        {4'd9,  1'b0, 2'b00, 16'h0000, 8'h00, 16'h7842}, // R9 pending
        {4'd9,  1'b1, 2'b10, 16'h4000, 8'h00, 16'h3842}, // R9
        {4'd9,  1'b0, 2'b00, 16'h0000, 8'h60, 16'h3842}, // R9 started
        {4'd4,  1'b0, 2'b00, 16'h0000, 8'hC0, 16'h7842}, // R4 during training
        {4'd9,  1'b1, 2'b10, 16'h4000, 8'h60, 16'h3842}, // R9
        {4'd5,  1'b0, 2'b00, 16'h0000, 8'h00, 16'h7042}, // R5 completion
        {4'd6,  1'b1, 2'b10, 16'h4000, 8'h00, 16'h3042}, // R6
        {4'd9,  1'b0, 2'b00, 16'h0000, 8'h40, 16'h3842}, // R9 cfg only
        {4'd5,  1'b0, 2'b00, 16'h0000, 8'h00, 16'h3042}, // R5 no event
        {4'd3,  1'b0, 2'b00, 16'h0000, 8'h04, 16'h7042}, // R3 hw fix
        {4'd6,  1'b1, 2'b10, 16'hC000, 8'h00, 16'h3042}  // R6
    };

    task automatic check(input logic [15:0] exp, input string req);
        n_cmp++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, cfg_rdata, exp);
        end
    endtask

    task automatic idle_in();
        cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = 16'h0;
        {retrain_wr, ltssm_cfg_rec, train_started, dl_down,
         hw_bw_auto, hw_bw_fix, phy_bw_chg, phy_bw_auto} = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(16'h1000, "R1 in reset");
        dl_active = 1'b1; neg_width = 6'h04; neg_speed = 4'h2;
        rst = 1'b0;
        @(negedge clk);
        check(16'h3042, "R1 first cycle");

        for (int i = 0; i < NV; i++) begin
            cfg_wr    = VEC[i][42];
            cfg_be    = VEC[i][41:40];
            cfg_wdata = VEC[i][39:24];
            {retrain_wr, ltssm_cfg_rec, train_started, dl_down,
             hw_bw_auto, hw_bw_fix, phy_bw_chg, phy_bw_auto} = VEC[i][23:16];
            @(negedge clk);
            check(VEC[i][15:0], $sformatf("R%0d vec %0d", VEC[i][46:43], i));
        end
        idle_in();

        dl_active = 1'b0;
        @(negedge clk);
        check(16'h1042, "R10 link inactive");

        neg_width = 6'h10; neg_speed = 4'h3;
        @(negedge clk);
        check(16'h1103, "R12 new width/speed");

        hw_bw_auto = 1'b1;
        #1 check(16'h1103, "R13 before edge");
        @(negedge clk);
        check(16'h9103, "R13 after edge");
        hw_bw_auto = 1'b0;
        cfg_wr = 1'b1; cfg_be = 2'b10; cfg_wdata = 16'h8000;
        #1 check(16'h9103, "R13 read pre-clear");
        @(negedge clk);
        check(16'h1103, "R13 cleared");
        idle_in();

        hw_bw_fix = 1'b1;
        @(negedge clk);
        hw_bw_fix = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(16'h1000, "R1 mid-run reset");
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule